// File: doc/BRIEF.md
# Outer PRG Bank Override Register

This block sits beside an existing cartridge bank mapper and takes over the upper program-ROM address lines for one fixed CPU address window. The base mapper decodes its own register writes and gives a write strobe. This block samples that strobe on the system clock. When the strobe goes high and CPU address bit 2 is low, five CPU data bits are stored in an override register. Because the base strobe already qualifies the other address lines, the register shows up across every address that matches the mask, with A2 low.

The block watches CPU A14 and A13. When A14 is 1 and A13 is 0, the override window is active. In that window, the final program-ROM lines A13 to A17 come from the override register, and an active-low bank-select output goes low. For any other combination of A14 and A13, the base mapper's A13 to A17 lines pass through unchanged and bank-select stays high. The base mapper keeps its own connection to A13 and A14, so its internal decoding does not change.

Top module: `prg_outer_override`

## Requirements
- R1: While `rstN` is low, the override register is cleared to zero on each clock edge. After reset, inside the window, `prgOut` reads 0.
- R2: If `wrStrobe` is sampled high at a rising clock edge, was low at the edge before, and `cpuA2` is 0, then `cpuData` is stored at that edge. The new value appears on `prgOut` (inside the window) after that edge.
- R3: A rising strobe sampled while `cpuA2` is 1 leaves the override register unchanged.
- R4: Holding `wrStrobe` high for several cycles stores data only once, at the first high sample. Data changes later in the same pulse are ignored.
- R5: Inside the window (`cpuA14`=1, `cpuA13`=0), `prgOut` bits 0 to 3 (program A13 to A16) equal override register bits 0 to 3.
- R6: Inside the window, `prgOut` bit 4 (program A17) equals override register bit 4.
- R7: For the other three combinations of `cpuA14`/`cpuA13`, `prgOut` equals `basePrg` bit for bit.
- R8: `bankSelN` is 0 exactly when `cpuA14`=1 and `cpuA13`=0. Otherwise it is 1.
- R9: A capture does not depend on the state of `cpuA14`/`cpuA13` during the write. Aliased writes outside the window load the register just the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuA14 | input | 1 | CPU address bit 14 |
| cpuA13 | input | 1 | CPU address bit 13 |
| cpuA2 | input | 1 | CPU address bit 2, qualifies the register write |
| cpuData | input | 5 | CPU data bits D0 to D4 |
| wrStrobe | input | 1 | Base mapper's decoded write strobe, active high |
| basePrg | input | 5 | Base mapper's program A13..A17 (bit 0 = A13) |
| prgOut | output | 5 | Final program A13..A17 (bit 0 = A13) |
| bankSelN | output | 1 | Low while the override window is selected |

## Verification
The assertions assume that `wrStrobe`, `cpuA2` and `cpuData` are held steady around each clock edge. They also assume that one strobe pulse belongs to one bus write, so a sampled rise means exactly one capture. The stimulus changes every input at the falling clock edge only. It keeps the strobe low through reset and returns it low between writes, except in the stretch that deliberately holds a pulse for several cycles.

// File: rtl/prgovr_pkg.sv
package prgovr_pkg;
  typedef struct packed {
    logic load;    // capture data into the override register
    logic window;  // CPU address lies in the override window
  } ovrCtrl_t;
endpackage

// File: rtl/prgovr_ctrl.sv
module prgovr_ctrl
  import prgovr_pkg::*;
#(
  parameter logic [1:0] WINDOW_SEL = 2'b10  // {A14, A13} pattern of the window
) (
  input  logic     clk,
  input  logic     wrStrobe,
  input  logic     cpuA2,
  input  logic     cpuA14,
  input  logic     cpuA13,
  output ovrCtrl_t ctrl
);
  logic strobeLast;

  // tracks the strobe every edge, reset included, so a rise is never invented
  always_ff @(posedge clk) strobeLast <= wrStrobe;

  always_comb begin
    ctrl.load   = wrStrobe & ~strobeLast & ~cpuA2;
    ctrl.window = ({cpuA14, cpuA13} == WINDOW_SEL);
  end
endmodule

// File: rtl/prgovr_dp.sv
module prgovr_dp
  import prgovr_pkg::*;
#(
  parameter int LINES = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ovrCtrl_t         ctrl,
  input  logic [LINES-1:0] cpuData,
  input  logic [LINES-1:0] basePrg,
  output logic [LINES-1:0] prgOut,
  output logic             bankSelN
);
  logic [LINES-1:0] bankReg;

  always_ff @(posedge clk) begin
    if (!rstN)          bankReg <= '0;
    else if (ctrl.load) bankReg <= cpuData;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_lineMux
    assign prgOut[i] = ctrl.window ? bankReg[i] : basePrg[i];
  end

  assign bankSelN = ~ctrl.window;
endmodule

// File: rtl/prg_outer_override.sv
module prg_outer_override
  import prgovr_pkg::*;
#(
  parameter int         LINES      = 5,
  parameter logic [1:0] WINDOW_SEL = 2'b10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuA14,
  input  logic             cpuA13,
  input  logic             cpuA2,
  input  logic [LINES-1:0] cpuData,
  input  logic             wrStrobe,
  input  logic [LINES-1:0] basePrg,
  output logic [LINES-1:0] prgOut,
  output logic             bankSelN
);
  ovrCtrl_t ctrl;

  prgovr_ctrl #(.WINDOW_SEL(WINDOW_SEL)) u_ctrl (
    .clk(clk), .wrStrobe(wrStrobe), .cpuA2(cpuA2),
    .cpuA14(cpuA14), .cpuA13(cpuA13), .ctrl(ctrl)
  );

  prgovr_dp #(.LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cpuData(cpuData),
    .basePrg(basePrg), .prgOut(prgOut), .bankSelN(bankSelN)
  );
endmodule

// File: rtl/prg_outer_override_chk.sv
module prg_outer_override_chk #(
  parameter int LINES = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuA14,
  input logic             cpuA13,
  input logic             cpuA2,
  input logic [LINES-1:0] cpuData,
  input logic             wrStrobe,
  input logic [LINES-1:0] basePrg,
  input logic [LINES-1:0] prgOut,
  input logic             bankSelN,
  input logic [LINES-1:0] heldBank
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> heldBank == '0);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !$past(wrStrobe) && !cpuA2) |=> heldBank == $past(cpuData));

  assert_a2_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !$past(wrStrobe) && cpuA2) |=> $stable(heldBank));

  assert_single_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && $past(wrStrobe)) |=> $stable(heldBank));

  assert_window_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuA14 && !cpuA13) |-> prgOut[3:0] == heldBank[3:0]);

  assert_window_a17_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuA14 && !cpuA13) |-> prgOut[4] == heldBank[4]);

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuA14 && !cpuA13) |-> prgOut == basePrg);

  assert_banksel_R8: assert property (@(posedge clk) disable iff (!rstN)
    bankSelN == !(cpuA14 && !cpuA13));
endmodule

bind prg_outer_override prg_outer_override_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .cpuA14(cpuA14), .cpuA13(cpuA13), .cpuA2(cpuA2),
  .cpuData(cpuData), .wrStrobe(wrStrobe), .basePrg(basePrg),
  .prgOut(prgOut), .bankSelN(bankSelN), .heldBank(u_dp.bankReg)
);

// File: tb/prg_outer_override_test.sv
`timescale 1ns/1ps
module prg_outer_override_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuA14 = 1'b1, cpuA13 = 1'b0, cpuA2 = 1'b0;
  logic [4:0] cpuData = '0;
  logic       wrStrobe = 1'b0;
  logic [4:0] basePrg = 5'h0b;
  logic [4:0] prgOut;
  logic       bankSelN;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  prg_outer_override uut (
    .clk(clk), .rstN(rstN), .cpuA14(cpuA14), .cpuA13(cpuA13), .cpuA2(cpuA2),
    .cpuData(cpuData), .wrStrobe(wrStrobe), .basePrg(basePrg),
    .prgOut(prgOut), .bankSelN(bankSelN)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, compared every clock
  int  modelBank = 0;
  bit  modelLast = 0;
  always @(posedge clk) begin
    bit win;
    if (!rstN) modelBank = 0;
    else if (wrStrobe && !modelLast && !cpuA2) modelBank = int'(cpuData);
    modelLast = wrStrobe;
    #1;
    win = cpuA14 && !cpuA13;
    if (!rstN) check("R1", int'(prgOut), win ? 0 : int'(basePrg));
    else if (win) check("R5 R6", int'(prgOut), modelBank);
    else check("R7", int'(prgOut), int'(basePrg));
    check("R8", int'(bankSelN), win ? 0 : 1);
  end

  task automatic drive(input bit a14, input bit a13, input bit a2,
                       input int d, input bit s, input int b);
    @(negedge clk);
    cpuA14 = a14; cpuA13 = a13; cpuA2 = a2;
    cpuData = 5'(d); wrStrobe = s; basePrg = 5'(b);
    @(posedge clk); #2;
  endtask

  task automatic writeReg(input bit a14, input bit a13, input bit a2, input int d);
    drive(a14, a13, a2, d, 1'b1, 5'h03);
    drive(a14, a13, a2, d, 1'b0, 5'h03);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) drive(1, 0, 0, 5'h1f, 0, 5'h0b);
    rstN = 1'b1;
    drive(1, 0, 0, 5'h1f, 0, 5'h0b);
    check("R1", int'(prgOut), 0);

    // aliased write with the window off, then look inside the window
    writeReg(0, 0, 0, 5'h15);
    drive(1, 0, 1, 0, 0, 5'h0b);
    check("R9", int'(prgOut), 5'h15);
    check("R2", int'(prgOut), 5'h15);

    // capture visible right after the edge of the rise
    drive(1, 0, 0, 5'h0e, 1, 5'h0b);
    check("R2", int'(prgOut), 5'h0e);
    drive(1, 0, 0, 5'h0e, 0, 5'h0b);

    writeReg(1, 0, 1, 5'h0a);
    check("R3", int'(prgOut), 5'h0e);

    // held pulse: only first data counts
    drive(1, 0, 0, 5'h07, 1, 5'h00);
    drive(1, 0, 0, 5'h18, 1, 5'h00);
    drive(1, 0, 0, 5'h1b, 1, 5'h00);
    check("R4", int'(prgOut), 5'h07);
    drive(1, 0, 0, 5'h1b, 0, 5'h00);
    check("R4", int'(prgOut), 5'h07);

    writeReg(1, 1, 0, 5'h10);
    drive(1, 0, 1, 0, 0, 5'h0f);
    check("R6", int'(prgOut[4]), 1);
    check("R5", int'(prgOut[3:0]), 0);
    check("R9", int'(prgOut), 5'h10);

    writeReg(0, 1, 0, 5'h0f);
    drive(1, 0, 1, 0, 0, 5'h10);
    check("R5", int'(prgOut[3:0]), 5'hf);
    check("R6", int'(prgOut[4]), 0);

    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 32; b += 9) begin
        bit win;
        win = (c == 2);
        drive(c[1], c[0], 1, 0, 0, b);
        check(win ? "R5" : "R7", int'(prgOut), win ? 5'h0f : b);
        check("R8", int'(bankSelN), win ? 0 : 1);
      end
    end

    rstN = 1'b0;
    drive(1, 0, 0, 0, 0, 5'h04);
    rstN = 1'b1;
    drive(1, 0, 0, 0, 0, 5'h04);
    check("R1", int'(prgOut), 0);
    finish();
  end
endmodule